// File: doc/BRIEF.md
# Scoreboarded Warp Issue Selector

This block is the issue stage of a multithreaded processor core. It holds one pending instruction for each of 32 hardware warps. Fetch loads a slot by naming a warp, an instruction tag, two source registers, a destination register and a one-bit class weight. Every cycle the block looks at the per-warp scoreboard and picks one slot whose operands and destination are all free. That slot is shown to the execution unit as the issued warp and tag. It is consumed when the execution unit accepts it.

Each warp has one pending bit per register. An accepted issue sets the bit for the instruction's destination. A writeback event naming a warp and a register clears that bit. The highest register index stands for the warp's shared-memory target and is tracked the same way as any other register.

The choice rotates round-robin over the warps that are ready, and high-class instructions go ahead of low-class ones. A warp whose slot is refilled in the cycle it issues can issue again in the next cycle, provided it still wins arbitration. A younger instruction that does not depend on an older, slower one can issue past it, so results may come back out of order.

Top module: `warp_issue_sel`

## Requirements
- R1: After reset no slot is occupied (`slotBusy` is all zero) and `issueValid` is low. The round-robin pointer starts at warp 0.
- R2: An insert into a free slot makes that slot occupied in the next cycle. An insert into an occupied slot that is not being accepted in the same cycle is dropped, and the slot keeps its old tag.
- R3: An occupied slot is eligible only when the pending bits of its warp are clear for its source A, its source B and its destination. Register index NUM_REGS-1 (15) is the shared-memory target and blocks in the same way.
- R4: At most one warp is presented per cycle, and only from an occupied slot. When no slot is eligible, `issueValid` is low and the round-robin pointer keeps its value.
- R5: The search for a winner starts at the pointer and wraps from warp 31 to warp 0. After an accepted issue the pointer moves to the warp after the one granted.
- R6: If any eligible slot has the high class (`insHiPri`=1), only high-class slots compete. Within a class the round-robin order decides.
- R7: An issue accepted with `issueReady`=1 frees the slot and sets the warp's pending bit for the destination. With `issueReady`=0 the slot, the scoreboard and the pointer are unchanged.
- R8: A writeback clears the pending bit for (`wbWarp`, `wbReg`). An independent younger instruction of a warp may issue while an older destination of the same warp is still pending.
- R9: An insert to the warp being accepted in the same cycle is taken. The new instruction is eligible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insValid | input | 1 | Insert strobe from fetch |
| insWarp | input | 5 | Warp slot to load |
| insTag | input | 8 | Instruction tag |
| insSrcA | input | 4 | First source register |
| insSrcB | input | 4 | Second source register |
| insDst | input | 4 | Destination register (15 = shared-memory target) |
| insHiPri | input | 1 | Class weight, 1 = high |
| wbValid | input | 1 | Writeback release strobe |
| wbWarp | input | 5 | Warp of the released register |
| wbReg | input | 4 | Released register |
| issueReady | input | 1 | Execution unit accepts the presented issue |
| issueValid | output | 1 | An instruction is presented |
| issueWarp | output | 5 | Warp of the presented instruction |
| issueTag | output | 8 | Tag of the presented instruction |
| issueDst | output | 4 | Destination of the presented instruction |
| slotBusy | output | 32 | Occupancy of each warp slot |

## Verification
The bench holds a slot behind a pending source, and then behind a pending shared-memory destination, and checks that nothing issues until the matching writeback. A design that ignored any operand of the readiness check would issue early. It stalls the execution unit with three warps ready and the pointer above all of them. A design without wraparound would pick the wrong warp, and one that moved state on an unaccepted issue would lose or repeat a slot. It also checks that a high-class slot beats a low-class one sitting earlier in the rotation, that a refill in the same cycle as an accept is kept rather than dropped, and that an insert into an occupied slot does not overwrite the tag that is waiting there.

// File: rtl/warp_issue_pkg.sv
package warp_issue_pkg;
  parameter int NUM_WARPS = 32;
  parameter int NUM_REGS  = 16;
  parameter int TAG_W     = 8;
  localparam int WARP_W   = $clog2(NUM_WARPS);
  localparam int REG_W    = $clog2(NUM_REGS);

  // strobes from control to datapath
  typedef struct packed {
    logic              selValid;
    logic [WARP_W-1:0] selWarp;
    logic              fire;
    logic              insertOk;
  } issue_strobe_t;
endpackage

// File: rtl/warp_issue_ctrl.sv
module warp_issue_ctrl
  import warp_issue_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_WARPS-1:0] readyVec,
  input  logic [NUM_WARPS-1:0] hiVec,
  input  logic [NUM_WARPS-1:0] slotBusy,
  input  logic                 insValid,
  input  logic [WARP_W-1:0]    insWarp,
  input  logic                 issueReady,
  output issue_strobe_t        strobe
);
  logic [WARP_W-1:0]    rrPtr;
  logic [NUM_WARPS-1:0] hiReady;
  logic [NUM_WARPS-1:0] candVec;
  logic                 found;
  logic [WARP_W-1:0]    winWarp;
  logic                 fire;

  assign hiReady = readyVec & hiVec;
  assign candVec = (|hiReady) ? hiReady : readyVec;

  always_comb begin
    found   = 1'b0;
    winWarp = rrPtr;
    for (int i = 0; i < NUM_WARPS; i++) begin
      logic [WARP_W-1:0] idx;
      idx = WARP_W'((int'(rrPtr) + i) % NUM_WARPS);
      if (!found && candVec[idx]) begin
        found   = 1'b1;
        winWarp = idx;
      end
    end
  end

  assign fire = found && issueReady;

  always_comb begin
    strobe.selValid = found;
    strobe.selWarp  = winWarp;
    strobe.fire     = fire;
    strobe.insertOk = insValid &&
                      (!slotBusy[insWarp] || (fire && (winWarp == insWarp)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (fire) begin
      if (int'(winWarp) == NUM_WARPS - 1) rrPtr <= '0;
      else                                rrPtr <= winWarp + 1'b1;
    end
  end
endmodule

// File: rtl/warp_issue_data.sv
module warp_issue_data
  import warp_issue_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [WARP_W-1:0]    insWarp,
  input  logic [TAG_W-1:0]     insTag,
  input  logic [REG_W-1:0]     insSrcA,
  input  logic [REG_W-1:0]     insSrcB,
  input  logic [REG_W-1:0]     insDst,
  input  logic                 insHiPri,
  input  logic                 wbValid,
  input  logic [WARP_W-1:0]    wbWarp,
  input  logic [REG_W-1:0]     wbReg,
  input  issue_strobe_t        strobe,
  output logic [NUM_WARPS-1:0] readyVec,
  output logic [NUM_WARPS-1:0] hiVec,
  output logic [NUM_WARPS-1:0] slotBusy,
  output logic [TAG_W-1:0]     selTag,
  output logic [REG_W-1:0]     selDst
);
  logic [NUM_WARPS-1:0]               busyQ;
  logic [NUM_WARPS-1:0]               hiQ;
  logic [TAG_W-1:0]                   tagQ  [NUM_WARPS];
  logic [REG_W-1:0]                   srcAQ [NUM_WARPS];
  logic [REG_W-1:0]                   srcBQ [NUM_WARPS];
  logic [REG_W-1:0]                   dstQ  [NUM_WARPS];
  logic [NUM_WARPS-1:0][NUM_REGS-1:0] pendQ;

  generate
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_ready
      assign readyVec[w] = busyQ[w] && !pendQ[w][srcAQ[w]] &&
                           !pendQ[w][srcBQ[w]] && !pendQ[w][dstQ[w]];
    end
  endgenerate

  assign hiVec    = hiQ;
  assign slotBusy = busyQ;
  assign selTag   = tagQ[strobe.selWarp];
  assign selDst   = dstQ[strobe.selWarp];

  // slot storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= '0;
      hiQ   <= '0;
      for (int w = 0; w < NUM_WARPS; w++) begin
        tagQ[w]  <= '0;
        srcAQ[w] <= '0;
        srcBQ[w] <= '0;
        dstQ[w]  <= '0;
      end
    end else begin
      if (strobe.fire) busyQ[strobe.selWarp] <= 1'b0;
      if (strobe.insertOk) begin
        busyQ[insWarp] <= 1'b1;
        hiQ[insWarp]   <= insHiPri;
        tagQ[insWarp]  <= insTag;
        srcAQ[insWarp] <= insSrcA;
        srcBQ[insWarp] <= insSrcB;
        dstQ[insWarp]  <= insDst;
      end
    end
  end

  // scoreboard: release first, then claim
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
    end else begin
      if (wbValid)     pendQ[wbWarp][wbReg] <= 1'b0;
      if (strobe.fire) pendQ[strobe.selWarp][dstQ[strobe.selWarp]] <= 1'b1;
    end
  end
endmodule

// File: rtl/warp_issue_sel.sv
module warp_issue_sel
  import warp_issue_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 insValid,
  input  logic [WARP_W-1:0]    insWarp,
  input  logic [TAG_W-1:0]     insTag,
  input  logic [REG_W-1:0]     insSrcA,
  input  logic [REG_W-1:0]     insSrcB,
  input  logic [REG_W-1:0]     insDst,
  input  logic                 insHiPri,
  input  logic                 wbValid,
  input  logic [WARP_W-1:0]    wbWarp,
  input  logic [REG_W-1:0]     wbReg,
  input  logic                 issueReady,
  output logic                 issueValid,
  output logic [WARP_W-1:0]    issueWarp,
  output logic [TAG_W-1:0]     issueTag,
  output logic [REG_W-1:0]     issueDst,
  output logic [NUM_WARPS-1:0] slotBusy
);
  issue_strobe_t        strobe;
  logic [NUM_WARPS-1:0] readyVec;
  logic [NUM_WARPS-1:0] hiVec;

  warp_issue_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .readyVec   (readyVec),
    .hiVec      (hiVec),
    .slotBusy   (slotBusy),
    .insValid   (insValid),
    .insWarp    (insWarp),
    .issueReady (issueReady),
    .strobe     (strobe)
  );

  warp_issue_data u_data (
    .clk      (clk),
    .rstN     (rstN),
    .insWarp  (insWarp),
    .insTag   (insTag),
    .insSrcA  (insSrcA),
    .insSrcB  (insSrcB),
    .insDst   (insDst),
    .insHiPri (insHiPri),
    .wbValid  (wbValid),
    .wbWarp   (wbWarp),
    .wbReg    (wbReg),
    .strobe   (strobe),
    .readyVec (readyVec),
    .hiVec    (hiVec),
    .slotBusy (slotBusy),
    .selTag   (issueTag),
    .selDst   (issueDst)
  );

  assign issueValid = strobe.selValid;
  assign issueWarp  = strobe.selWarp;
endmodule

// File: rtl/warp_issue_chk.sv
module warp_issue_chk
  import warp_issue_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 insValid,
  input logic [WARP_W-1:0]    insWarp,
  input logic                 wbValid,
  input logic                 issueReady,
  input logic                 issueValid,
  input logic [WARP_W-1:0]    issueWarp,
  input logic [TAG_W-1:0]     issueTag,
  input logic [NUM_WARPS-1:0] slotBusy
);
  // R4
  issue_from_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> slotBusy[issueWarp]);

  // R4
  idle_when_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotBusy == '0) |-> !issueValid);

  // R7
  stall_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !issueReady && !insValid && !wbValid) |=>
      (issueValid && $stable(issueWarp) && $stable(issueTag)));

  // R7
  accept_frees_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueReady && !insValid) |=> !slotBusy[$past(issueWarp)]);

  // R2
  insert_fills_chk: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && !slotBusy[insWarp]) |=> slotBusy[$past(insWarp)]);
endmodule

bind warp_issue_sel warp_issue_chk u_chk (.*);

// File: tb/warp_issue_sel_test.sv
module warp_issue_sel_test;
  import warp_issue_pkg::*;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 insValid = 1'b0;
  logic [WARP_W-1:0]    insWarp = '0;
  logic [TAG_W-1:0]     insTag = '0;
  logic [REG_W-1:0]     insSrcA = '0;
  logic [REG_W-1:0]     insSrcB = '0;
  logic [REG_W-1:0]     insDst = '0;
  logic                 insHiPri = 1'b0;
  logic                 wbValid = 1'b0;
  logic [WARP_W-1:0]    wbWarp = '0;
  logic [REG_W-1:0]     wbReg = '0;
  logic                 issueReady = 1'b1;
  logic                 issueValid;
  logic [WARP_W-1:0]    issueWarp;
  logic [TAG_W-1:0]     issueTag;
  logic [REG_W-1:0]     issueDst;
  logic [NUM_WARPS-1:0] slotBusy;

  int checks = 0;
  int errors = 0;
  logic [WARP_W+TAG_W-1:0] expQ [$];

  always #5 clk = ~clk;

  warp_issue_sel uut (.*);

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_issue(input int w, input int tag);
    expQ.push_back({WARP_W'(w), TAG_W'(tag)});
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_insert(input int w, input int tag, input int a, input int b,
                           input int d, input bit hi);
    insValid = 1'b1; insWarp = WARP_W'(w); insTag = TAG_W'(tag);
    insSrcA = REG_W'(a); insSrcB = REG_W'(b); insDst = REG_W'(d); insHiPri = hi;
    tick(1);
    insValid = 1'b0;
  endtask

  task automatic do_wb(input int w, input int r);
    wbValid = 1'b1; wbWarp = WARP_W'(w); wbReg = REG_W'(r);
    tick(1);
    wbValid = 1'b0;
  endtask

  // monitor: compare every accepted issue against the expected queue
  always @(negedge clk) begin
    if (rstN && issueValid && issueReady) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected issue actual=%0h/%0h expected=none",
                 issueWarp, issueTag);
      end else begin
        logic [WARP_W+TAG_W-1:0] e;
        e = expQ.pop_front();
        if ({issueWarp, issueTag} != e) begin
          errors++;
          $display("FAIL R5 issue order actual=%0h/%0h expected=%0h/%0h",
                   issueWarp, issueTag, e[WARP_W+TAG_W-1:TAG_W], e[TAG_W-1:0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    @(negedge clk);
    chk(int'(issueValid), 0, "R1 valid");
    chk(int'(slotBusy), 0, "R1 slots");
    tick(1);

    // R3: dependency on a pending source
    expect_issue(3, 'h11);
    do_insert(3, 'h11, 1, 2, 5, 0);
    tick(2);
    do_insert(3, 'h12, 5, 2, 6, 0);
    tick(3);
    chk(int'(issueValid), 0, "R3 src blocked");
    chk(int'(slotBusy[3]), 1, "R3 slot held");
    expect_issue(3, 'h12);
    do_wb(3, 5);
    tick(3);
    chk(int'(slotBusy[3]), 0, "R8 released");

    // R3: shared-memory target as destination
    expect_issue(8, 'h80);
    do_insert(8, 'h80, 1, 2, 15, 0);
    tick(2);
    do_insert(8, 'h81, 1, 2, 15, 0);
    tick(3);
    chk(int'(issueValid), 0, "R3 shm blocked");
    expect_issue(8, 'h81);
    do_wb(8, 15);
    tick(3);

    // R5 wraparound, pointer at 9; R7 stall holds
    issueReady = 1'b0;
    do_insert(0, 'h01, 1, 2, 7, 0);
    do_insert(1, 'h02, 1, 2, 7, 0);
    do_insert(2, 'h03, 1, 2, 7, 0);
    tick(2);
    chk(int'(issueWarp), 0, "R5 wrap winner");
    chk(int'(slotBusy[2:0]), 7, "R7 stall keeps slots");
    expect_issue(0, 'h01); expect_issue(1, 'h02); expect_issue(2, 'h03);
    issueReady = 1'b1;
    tick(4);

    // R5 start from pointer 3
    issueReady = 1'b0;
    do_insert(1, 'h21, 1, 2, 8, 0);
    do_insert(20, 'h22, 1, 2, 7, 0);
    tick(1);
    chk(int'(issueWarp), 20, "R5 pointer start");
    expect_issue(20, 'h22); expect_issue(1, 'h21);
    issueReady = 1'b1;
    tick(4);

    // R6 class beats rotation, pointer at 2
    issueReady = 1'b0;
    do_insert(4, 'h44, 1, 2, 7, 0);
    do_insert(10, 'hA0, 1, 2, 7, 1);
    tick(1);
    chk(int'(issueWarp), 10, "R6 high class");
    expect_issue(10, 'hA0); expect_issue(4, 'h44);
    issueReady = 1'b1;
    tick(4);

    // R8 younger independent issues past older pending destination
    expect_issue(5, 'h50);
    do_insert(5, 'h50, 1, 2, 8, 1);
    tick(2);
    expect_issue(5, 'h51);
    do_insert(5, 'h51, 1, 2, 9, 0);
    tick(2);
    do_insert(5, 'h52, 8, 2, 10, 0);
    tick(3);
    chk(int'(issueValid), 0, "R8 older still pending");
    expect_issue(5, 'h52);
    do_wb(5, 8);
    tick(3);

    // R9 refill in the accept cycle
    issueReady = 1'b0;
    do_insert(6, 'h60, 1, 2, 11, 0);
    tick(1);
    expect_issue(6, 'h60); expect_issue(6, 'h61);
    issueReady = 1'b1;
    do_insert(6, 'h61, 1, 2, 12, 0);
    tick(3);
    chk(int'(slotBusy[6]), 0, "R9 refill issued");

    // R2 insert into occupied slot is dropped
    issueReady = 1'b0;
    do_insert(7, 'h70, 1, 2, 11, 0);
    do_insert(7, 'h71, 1, 2, 13, 0);
    tick(1);
    chk(int'(issueTag), 'h70, "R2 tag kept");
    expect_issue(7, 'h70);
    issueReady = 1'b1;
    tick(3);
    chk(int'(slotBusy[7]), 0, "R2 no second entry");
    chk(int'(issueValid), 0, "R4 idle");
    chk(expQ.size(), 0, "R5 all expected issued");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule